// File: doc/BRIEF.md
# Occupancy Limit Calculator

This block works out how many thread blocks of one kernel configuration can be resident on a single streaming multiprocessor at the same time. It takes three inputs: the thread count of a block, the registers each thread uses and the shared-memory bytes each block requests. From these it derives one limit for each of four resources: registers, shared memory, warp slots and block slots. The smallest of the four sets the number of resident blocks.

The block reports the resident block count and the active warp count. It gives occupancy in fixed point, as tenths of a percent of the warp maximum. It also returns a code naming the resource that sets the limit. All machine limits are parameters: warp size, warp maximum, block maximum, register count, shared-memory capacity and the allocation granularities. The granularities must be powers of two.

A caller pulses a start input while the block is idle. The block then runs its divisions one after another through a single shared iterative divider. It raises a one-cycle completion pulse and holds the results until the next run completes. A request with zero threads is flagged as an error.

Top module: `occ_calc`

## Requirements
- R1: Warps per block equal the thread count divided by the warp size (32), rounded up.
- R2: Registers per warp are registers per thread times 32, rounded up to a multiple of 256. The register-file total (65536) divided by that gives a warp count. That count divided by warps per block gives the register limit. A request of zero registers yields a register limit equal to the block maximum.
- R3: The shared-memory request is rounded up to a multiple of 128 bytes. The capacity (233472 bytes) divided by the rounded amount gives the shared-memory limit. A zero request yields a limit equal to the block maximum.
- R4: The warp limit is the warp maximum (48) divided by warps per block. The block limit is 32. The resident block count `blocks_o` is the minimum of the register, shared-memory, warp and block limits.
- R5: `warps_o` equals resident blocks times warps per block, capped at 48. `pct_o` equals floor(`warps_o` × 1000 / 48), in tenths of a percent.
- R6: `limit_o` is 0 when the result equals the register limit. Otherwise it is 1 when it equals the shared-memory limit, otherwise 2 when it equals the warp limit, and otherwise 3 (block maximum). The checks are made in that order.
- R7: A start pulse seen while idle latches the inputs and raises `busy_o`. A start seen while busy is ignored. `done_o` is high for exactly one cycle per run. The result outputs change only in that cycle and otherwise hold, even when the inputs change.
- R8: A thread count of zero gives `err_o`=1, `blocks_o`=0, `warps_o`=0, `pct_o`=0 and `limit_o`=3. Any non-zero thread count gives `err_o`=0.
- R9: After reset, `busy_o`, `done_o`, `err_o` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a calculation when idle |
| thr_i | input | THR_W (11) | Threads per block |
| regs_i | input | REG_W (8) | Registers per thread |
| smem_i | input | SMEM_W (18) | Shared-memory bytes per block |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Zero-thread request flag |
| blocks_o | output | BLK_W (6) | Resident blocks |
| warps_o | output | WRP_W (6) | Active warps |
| pct_o | output | PCT_W (10) | Occupancy in tenths of a percent |
| limit_o | output | 2 | Limiting resource code |

## Verification
The bench builds the block with its default limits: 32-thread warps, 48 warps, 32 blocks, 65536 registers in 256-register units, and 233472 bytes of shared memory in 128-byte units. With these values every limiter code is reachable. The bench reaches a full 48-warp result, a register limit of zero blocks at 255 registers, and a tie between the shared-memory limit and the block maximum that the priority order must settle. The 11-bit thread input reaches 1024 threads, and the 18-bit shared-memory input covers requests just above one granule, which exercises rounding on every resource.

// File: rtl/occ_pkg.sv
package occ_pkg;

   typedef enum logic [1:0] {
      LIM_REGS   = 2'd0,
      LIM_SMEM   = 2'd1,
      LIM_WARPS  = 2'd2,
      LIM_BLOCKS = 2'd3
   } limit_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_DONE  = 2'd3
   } calc_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/occ_roundup.sv
module occ_roundup #(
   parameter int IN_W = 8,
   parameter int GRAN = 1
) (
   input  logic [IN_W-1:0] val_i,
   output logic [IN_W:0]   val_o
);
   localparam logic [IN_W:0] MASK = (IN_W+1)'(GRAN - 1);

   if (GRAN < 1 || (GRAN & (GRAN - 1)) != 0) begin : g_bad_gran
      $error("occ_roundup: GRAN must be a power of two");
   end

   if (GRAN == 1) begin : g_pass
      assign val_o = {1'b0, val_i};
   end else begin : g_mask
      assign val_o = ({1'b0, val_i} + MASK) & ~MASK;
   end
endmodule

// File: rtl/occ_divider.sv
module occ_divider #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] dividend_i,
   input  logic [W-1:0] divisor_i,
   output logic         done_o,
   output logic [W-1:0] quot_o
);
   localparam int CNT_W = $clog2(W + 1);

   logic [W-1:0]     rem_q, quo_q, dsr_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic [W:0]       trial;
   logic             fits;

   if (W < 2) begin : g_bad_w
      $error("occ_divider: W must be at least 2");
   end

   always_comb begin
      trial = {rem_q, quo_q[W-1]};
      fits  = (trial >= {1'b0, dsr_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         dsr_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            rem_q <= '0;
            quo_q <= dividend_i;
            dsr_q <= divisor_i;
            cnt_q <= CNT_W'(W);
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= fits ? W'(trial - {1'b0, dsr_q}) : W'(trial);
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               run_q  <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   assign quot_o = quo_q;

   AST_DIV_REMAINDER: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && (dsr_q != '0) |-> rem_q < dsr_q) else $error("remainder not below divisor"); // R2

   AST_DIV_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o) else $error("divider done longer than one cycle"); // R7
endmodule

// File: rtl/occ_limit_fold.sv
module occ_limit_fold
   import occ_pkg::*;
#(
   parameter int W          = 18,
   parameter int MAX_BLOCKS = 32
) (
   input  logic [W-1:0] lim_reg_i,
   input  logic [W-1:0] lim_smem_i,
   input  logic [W-1:0] lim_warp_i,
   output logic [W-1:0] blocks_o,
   output limit_e       code_o
);
   localparam logic [W-1:0] BLK_CAP = W'(MAX_BLOCKS);

   always_comb begin
      logic [W-1:0] m;
      m = BLK_CAP;
      if (lim_reg_i  < m) m = lim_reg_i;
      if (lim_smem_i < m) m = lim_smem_i;
      if (lim_warp_i < m) m = lim_warp_i;
      blocks_o = m;
      if (m == lim_reg_i)       code_o = LIM_REGS;
      else if (m == lim_smem_i) code_o = LIM_SMEM;
      else if (m == lim_warp_i) code_o = LIM_WARPS;
      else                      code_o = LIM_BLOCKS;
   end

   always_comb begin
      AST_FOLD_BOUND: assert (blocks_o <= BLK_CAP) else $error("fold above block cap"); // R4
   end
endmodule

// File: rtl/occ_calc.sv
module occ_calc
   import occ_pkg::*;
#(
   parameter int WARP_THREADS = 32,
   parameter int MAX_WARPS    = 48,
   parameter int MAX_BLOCKS   = 32,
   parameter int REG_TOTAL    = 65536,
   parameter int REG_GRAN     = 256,
   parameter int SMEM_BYTES   = 233472,
   parameter int SMEM_GRAN    = 128,
   parameter int PCT_SCALE    = 1000,
   parameter int THR_W        = 11,
   parameter int REG_W        = 8,
   parameter int SMEM_W       = 18,
   parameter int BLK_W        = $clog2(MAX_BLOCKS + 1),
   parameter int WRP_W        = $clog2(MAX_WARPS + 1),
   parameter int PCT_W        = $clog2(PCT_SCALE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [THR_W-1:0]  thr_i,
   input  logic [REG_W-1:0]  regs_i,
   input  logic [SMEM_W-1:0] smem_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [BLK_W-1:0]  blocks_o,
   output logic [WRP_W-1:0]  warps_o,
   output logic [PCT_W-1:0]  pct_o,
   output logic [1:0]        limit_o
);
   localparam int LOG_WT = $clog2(WARP_THREADS);
   localparam int WPB_W  = THR_W + 1 - LOG_WT;
   localparam int RSC_W  = REG_W + LOG_WT;
   localparam int RPW_W  = RSC_W + 1;
   localparam int SMA_W  = SMEM_W + 1;
   localparam int DIV_W  = imax(imax(imax($clog2(SMEM_BYTES + 1), $clog2(REG_TOTAL + 1)),
                                     imax($clog2(MAX_WARPS * PCT_SCALE + 1), SMA_W)),
                                imax(RPW_W, imax(WPB_W, $clog2(MAX_BLOCKS + 1))));
   localparam int PRD_W  = DIV_W + WPB_W;
   localparam int NSTEP  = 5;
   localparam logic [2:0] LAST_STEP = 3'(NSTEP - 1);

   if (WARP_THREADS < 1 || (WARP_THREADS & (WARP_THREADS - 1)) != 0) begin : g_bad_wt
      $error("occ_calc: WARP_THREADS must be a power of two");
   end
   if (THR_W <= LOG_WT) begin : g_bad_thr
      $error("occ_calc: THR_W too narrow for the warp size");
   end
   if (MAX_WARPS < 1 || MAX_BLOCKS < 1 || PCT_SCALE < 1) begin : g_bad_lim
      $error("occ_calc: limits must be positive");
   end

   // ---- per-resource granularity rounding -------------------------------
   logic [THR_W:0]     thr_rnd;
   logic [RSC_W-1:0]   reg_scaled;
   logic [RPW_W-1:0]   rpw_d;
   logic [SMA_W-1:0]   sma_d;
   logic [WPB_W-1:0]   wpb_d;

   occ_roundup #(.IN_W(THR_W), .GRAN(WARP_THREADS)) u_rnd_thr (
      .val_i(thr_i), .val_o(thr_rnd));

   assign reg_scaled = RSC_W'(regs_i) << LOG_WT;

   occ_roundup #(.IN_W(RSC_W), .GRAN(REG_GRAN)) u_rnd_reg (
      .val_i(reg_scaled), .val_o(rpw_d));

   occ_roundup #(.IN_W(SMEM_W), .GRAN(SMEM_GRAN)) u_rnd_smem (
      .val_i(smem_i), .val_o(sma_d));

   assign wpb_d = WPB_W'(thr_rnd >> LOG_WT);

   // ---- sequencing state -------------------------------------------------
   calc_state_e        state_q;
   logic [2:0]         step_q;
   logic [WPB_W-1:0]   wpb_q;
   logic [RPW_W-1:0]   rpw_q;
   logic [SMA_W-1:0]   sma_q;
   logic               err_q;
   logic [DIV_W-1:0]   slot_q [NSTEP];

   logic [DIV_W-1:0]   op_dvd, op_dsr, op_skipval;
   logic               op_skip;
   logic               div_start, div_done;
   logic [DIV_W-1:0]   div_quo;
   logic [DIV_W-1:0]   fold_blocks;
   limit_e             fold_code;
   logic [PRD_W-1:0]   warps_full;
   logic [DIV_W-1:0]   warps_cap;

   occ_limit_fold #(.W(DIV_W), .MAX_BLOCKS(MAX_BLOCKS)) u_fold (
      .lim_reg_i (slot_q[2]),
      .lim_smem_i(slot_q[3]),
      .lim_warp_i(slot_q[0]),
      .blocks_o  (fold_blocks),
      .code_o    (fold_code));

   always_comb begin
      warps_full = PRD_W'(fold_blocks) * PRD_W'(wpb_q);
      warps_cap  = (warps_full > PRD_W'(MAX_WARPS)) ? DIV_W'(MAX_WARPS) : DIV_W'(warps_full);
   end

   // Operand selection: step 0 warp slots, 1 warps by registers,
   // 2 blocks by registers, 3 blocks by shared memory, 4 percentage.
   always_comb begin
      op_dvd     = '0;
      op_dsr     = '0;
      op_skip    = 1'b0;
      op_skipval = '0;
      case (step_q)
         3'd0: begin
            op_dvd = DIV_W'(MAX_WARPS);
            op_dsr = DIV_W'(wpb_q);
         end
         3'd1: begin
            op_dvd  = DIV_W'(REG_TOTAL);
            op_dsr  = DIV_W'(rpw_q);
            op_skip = (rpw_q == '0);
         end
         3'd2: begin
            op_dvd     = slot_q[1];
            op_dsr     = DIV_W'(wpb_q);
            op_skip    = (rpw_q == '0);
            op_skipval = DIV_W'(MAX_BLOCKS);
         end
         3'd3: begin
            op_dvd     = DIV_W'(SMEM_BYTES);
            op_dsr     = DIV_W'(sma_q);
            op_skip    = (sma_q == '0);
            op_skipval = DIV_W'(MAX_BLOCKS);
         end
         default: begin
            op_dvd = warps_cap * DIV_W'(PCT_SCALE);
            op_dsr = DIV_W'(MAX_WARPS);
         end
      endcase
   end

   assign div_start = (state_q == ST_ISSUE) && !op_skip;

   occ_divider #(.W(DIV_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (div_start),
      .dividend_i(op_dvd),
      .divisor_i (op_dsr),
      .done_o    (div_done),
      .quot_o    (div_quo));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         step_q   <= '0;
         wpb_q    <= '0;
         rpw_q    <= '0;
         sma_q    <= '0;
         err_q    <= 1'b0;
         for (int i = 0; i < NSTEP; i++) slot_q[i] <= '0;
         done_o   <= 1'b0;
         err_o    <= 1'b0;
         blocks_o <= '0;
         warps_o  <= '0;
         pct_o    <= '0;
         limit_o  <= '0;
      end else begin
         done_o <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  wpb_q   <= wpb_d;
                  rpw_q   <= rpw_d;
                  sma_q   <= sma_d;
                  err_q   <= (thr_i == '0);
                  step_q  <= '0;
                  state_q <= (thr_i == '0) ? ST_DONE : ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (op_skip) begin
                  slot_q[step_q] <= op_skipval;
                  step_q         <= step_q + 3'd1;
               end else begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (div_done) begin
                  slot_q[step_q] <= div_quo;
                  if (step_q == LAST_STEP) begin
                     state_q <= ST_DONE;
                  end else begin
                     step_q  <= step_q + 3'd1;
                     state_q <= ST_ISSUE;
                  end
               end
            end
            default: begin
               err_o    <= err_q;
               blocks_o <= err_q ? '0 : BLK_W'(fold_blocks);
               warps_o  <= err_q ? '0 : WRP_W'(warps_cap);
               pct_o    <= err_q ? '0 : PCT_W'(slot_q[4]);
               limit_o  <= err_q ? 2'(LIM_BLOCKS) : 2'(fold_code);
               done_o   <= 1'b1;
               state_q  <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o) else $error("done held"); // R7

   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(blocks_o) && $stable(warps_o) && $stable(pct_o) && $stable(limit_o))
      else $error("result changed without done"); // R7

   AST_WARP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> warps_o <= WRP_W'(MAX_WARPS)) else $error("warps above cap"); // R5

   AST_BLOCK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> blocks_o <= BLK_W'(MAX_BLOCKS)) else $error("blocks above cap"); // R4

   AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && err_o |-> blocks_o == '0 && warps_o == '0 && pct_o == '0)
      else $error("error result not zero"); // R8

   AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o) else $error("busy while done"); // R7
endmodule

// File: tb/occ_calc_bench.sv
module occ_calc_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [10:0] thr_i = '0;
   logic [7:0]  regs_i = '0;
   logic [17:0] smem_i = '0;
   logic        busy_o, done_o, err_o;
   logic [5:0]  blocks_o, warps_o;
   logic [9:0]  pct_o;
   logic [1:0]  limit_o;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   occ_calc u_occ_calc (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .thr_i(thr_i), .regs_i(regs_i), .smem_i(smem_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
      .blocks_o(blocks_o), .warps_o(warps_o), .pct_o(pct_o), .limit_o(limit_o));

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   // Expected values straight from the requirement text.
   function automatic void model(input int thr, input int regs, input int smem,
                                 output int b, output int w, output int p,
                                 output int l, output int e);
      int wpb, rpw, lr, ls, lw, sa;
      if (thr == 0) begin
         b = 0; w = 0; p = 0; l = 3; e = 1;
         return;
      end
      e   = 0;
      wpb = (thr + 31) / 32;
      rpw = ((regs * 32 + 255) / 256) * 256;
      lr  = (rpw == 0) ? 32 : (65536 / rpw) / wpb;
      sa  = ((smem + 127) / 128) * 128;
      ls  = (sa == 0) ? 32 : 233472 / sa;
      lw  = 48 / wpb;
      b   = imin(imin(lr, ls), imin(lw, 32));
      w   = imin(b * wpb, 48);
      p   = (w * 1000) / 48;
      if (b == lr)      l = 0;
      else if (b == ls) l = 1;
      else if (b == lw) l = 2;
      else              l = 3;
   endfunction

   task automatic pulse_start(input int thr, input int regs, input int smem);
      @(negedge clk);
      thr_i   = 11'(thr);
      regs_i  = 8'(regs);
      smem_i  = 18'(smem);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      int cyc = 0;
      while (!done_o && cyc < 2000) begin
         @(negedge clk);
         cyc++;
      end
      chk({tag, " R7 completion seen"}, int'(done_o), 1);
   endtask

   task automatic check_result(input string tag, input int thr, input int regs, input int smem);
      int eb, ew, ep, el, ee;
      model(thr, regs, smem, eb, ew, ep, el, ee);
      chk({tag, " R4 blocks"},  int'(blocks_o), eb);
      chk({tag, " R5 warps"},   int'(warps_o),  ew);
      chk({tag, " R5 pct"},     int'(pct_o),    ep);
      chk({tag, " R6 limiter"}, int'(limit_o),  el);
      chk({tag, " R8 err"},     int'(err_o),    ee);
   endtask

   task automatic run_case(input string tag, input int thr, input int regs, input int smem);
      pulse_start(thr, regs, smem);
      chk({tag, " R7 busy after start"}, int'(busy_o), 1);
      wait_done(tag);
      check_result(tag, thr, regs, smem);
      @(negedge clk);
      chk({tag, " R7 done one cycle"}, int'(done_o), 0);
   endtask

   task automatic test_reset();
      chk("R9 busy at reset",   int'(busy_o),   0);
      chk("R9 done at reset",   int'(done_o),   0);
      chk("R9 err at reset",    int'(err_o),    0);
      chk("R9 blocks at reset", int'(blocks_o), 0);
      chk("R9 warps at reset",  int'(warps_o),  0);
      chk("R9 pct at reset",    int'(pct_o),    0);
      chk("R9 limit at reset",  int'(limit_o),  0);
   endtask

   task automatic test_stated_example();
      run_case("R2 256thr/64reg", 256, 64, 0);
      chk("R2 fixed 4 blocks", int'(blocks_o), 4);
      chk("R5 fixed 32 warps", int'(warps_o), 32);
      chk("R5 fixed 666 tenths", int'(pct_o), 666);
      chk("R6 fixed register limiter", int'(limit_o), 0);
   endtask

   task automatic test_hold_and_ignore();
      int dones = 0;
      int b0, w0, p0, l0;
      run_case("R7 base", 128, 32, 49152);
      b0 = blocks_o; w0 = warps_o; p0 = pct_o; l0 = limit_o;
      thr_i = 11'd64; regs_i = 8'd200; smem_i = 18'd5000;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (done_o) dones++;
      end
      chk("R7 no run without start", dones, 0);
      chk("R7 blocks held", int'(blocks_o), b0);
      chk("R7 warps held",  int'(warps_o),  w0);
      chk("R7 pct held",    int'(pct_o),    p0);
      chk("R7 limit held",  int'(limit_o),  l0);
      // a second start while busy must not change the run
      pulse_start(256, 48, 0);
      repeat (3) @(negedge clk);
      thr_i = 11'd1024; regs_i = 8'd255; smem_i = 18'd1;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_done("R7 busy-start");
      check_result("R7 busy-start", 256, 48, 0);
      dones = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (done_o) dones++;
      end
      chk("R7 ignored start made no run", dones, 0);
   endtask

   initial begin
      #(2_000_000);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #1;
      test_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_stated_example();
      run_case("R4 full warps", 256, 32, 0);
      run_case("R2 48 regs", 256, 48, 0);
      run_case("R3 smem limited", 128, 32, 49152);
      run_case("R3 large smem", 256, 32, 167936);
      run_case("R1 rounding 33thr", 33, 1, 1);
      run_case("R6 smem tie block max", 32, 16, 0);
      run_case("R2 zero regs", 32, 0, 0);
      run_case("R2 zero block result", 1024, 255, 0);
      run_case("R1 one thread", 1, 255, 233472);
      run_case("R8 zero threads", 0, 40, 1000);
      chk("R8 err set", int'(err_o), 1);
      run_case("R8 err clears", 64, 20, 256);
      chk("R8 err cleared", int'(err_o), 0);
      test_hold_and_ignore();
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule